// File: doc/BRIEF.md
# BCD Time-of-Day Calendar with Alarm

This block keeps wall-clock time for a chip that supplies a one-cycle 1 Hz tick enable. Seconds, minutes and hours are held as packed BCD bytes; the date is not broken into year, month and day but kept as a plain binary count of elapsed days, 15 bits wide. Software reaches every field through a small byte-wide register port with a 4-bit address. It writes data in the cycle `reg_wr` is high, and reads through a combinational data path.

An alarm compares the minute, the hour and the day count with programmed values. Each of these three comparisons has its own enable. The comparison is made once per minute, at the moment the seconds wrap to 00. A match latches a sticky flag, which software clears by writing a 1 to it. The interrupt line is the flag gated by an interrupt enable. A busy indication covers the cycle in which a tick updates the counters, and writes to the time fields in that cycle are dropped.

Top module: `bcd_tod_calendar`

## Requirements
- R1: After reset, every register reads 0x00 and `irq_o` is low.
- R2: Register map, by address. 0x0 is control. 0x1 is seconds, 0x2 minutes, 0x3 hours and 0x4 the day-count low byte. 0x5 is the day-count high byte; only bits 6:0 are stored and bit 7 reads 0. 0x6 is the alarm minute, 0x7 the alarm hour, 0x8 the alarm day low byte and 0x9 the alarm day high byte, which also keeps bits 6:0 only. Addresses 0xA to 0xF read 0x00. Written values read back.
- R3: On each counting tick the seconds advance in BCD. 59 wraps to 00 and carries into the minutes. Minutes wrap from 59 to 00 and carry into the hours. Hours wrap from 23 to 00 and increment the day count.
- R4: The counters advance only when `tick_1hz` is high and the run enable (control bit 0) is set. With run clear, ticks leave every field unchanged.
- R5: The day count wraps from 0x7FFF to 0x0000.
- R6: Control bit 7 is read-only. It reads 1 exactly in a cycle where `tick_1hz` is high and run is set. In such a cycle, writes to addresses 0x1 to 0x5 are ignored. Writes to control and to the alarm registers still take effect.
- R7: Control bit 3 enables the minute match, bit 4 the hour match and bit 5 the day match. When the seconds wrap to 00, the alarm flag (control bit 2) is set if at least one match is enabled and every enabled field equals the new time value.
- R8: With bits 3, 4 and 5 all clear, the alarm flag never sets.
- R9: Writing 1 to control bit 2 clears the alarm flag. Writing 0 to it has no effect. If an alarm match and a clearing write fall in the same cycle, the flag ends up set. Control bit 6 reads 0.
- R10: `irq_o` is high exactly when the alarm flag and the interrupt enable (control bit 1) are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle-per-second count enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Alarm interrupt |

## Verification
Two collisions matter here. The first is a software write to a time field, or to control, arriving in the very cycle a tick advances the counters. The second is the minute-boundary alarm match landing in the same cycle as a write-1-to-clear of the flag. The bench places a write exactly on a counting tick and checks the following. The time write is lost. Busy reads 1 in that cycle. A control or alarm write in that cycle is kept. A clear that coincides with a matching minute boundary leaves the flag set. A behavioural model holds the time as seconds-of-day plus a day integer. That model judges every cycle's read data and interrupt.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int ADDR_W = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 4'h0,
    A_SEC   = 4'h1,
    A_MIN   = 4'h2,
    A_HOUR  = 4'h3,
    A_DLO   = 4'h4,
    A_DHI   = 4'h5,
    A_AMIN  = 4'h6,
    A_AHOUR = 4'h7,
    A_ADLO  = 4'h8,
    A_ADHI  = 4'h9
  } reg_sel_e;

  // control bit positions
  localparam int C_RUN  = 0;
  localparam int C_AIEN = 1;
  localparam int C_FLAG = 2;
  localparam int C_MEN  = 3;
  localparam int C_HEN  = 4;
  localparam int C_DEN  = 5;
  localparam int C_BUSY = 7;

  // true when a packed-BCD field sits at its last value
  function automatic logic bcd_at_last(input logic [7:0] v, input logic [7:0] last);
    return v == last;
  endfunction

  // packed-BCD increment that returns to 00 after 'last'
  function automatic logic [7:0] bcd_next(input logic [7:0] v, input logic [7:0] last);
    if (v == last)         return 8'h00;
    else if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    else                   return {v[7:4], v[3:0] + 4'h1};
  endfunction
endpackage

// File: rtl/tod_time_core.sv
module tod_time_core
  import tod_pkg::*;
#(
  parameter int DAY_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [4:0]       wr_sel,   // 0 sec, 1 min, 2 hour, 3 day low, 4 day high
  input  logic [7:0]       wdata,
  output logic [7:0]       sec_o,
  output logic [7:0]       min_o,
  output logic [7:0]       hour_o,
  output logic [DAY_W-1:0] day_o,
  output logic [7:0]       sec_nx,
  output logic [7:0]       min_nx,
  output logic [7:0]       hour_nx,
  output logic [DAY_W-1:0] day_nx,
  output logic             min_edge_o
);
  localparam int HI_W = DAY_W - 8;

  logic [7:0]       sec_q, min_q, hour_q;
  logic [DAY_W-1:0] day_q;
  logic             sec_wrap, min_wrap, hour_wrap;

  assign sec_wrap  = step && bcd_at_last(sec_q, 8'h59);
  assign min_wrap  = sec_wrap && bcd_at_last(min_q, 8'h59);
  assign hour_wrap = min_wrap && bcd_at_last(hour_q, 8'h23);

  assign sec_nx  = step      ? bcd_next(sec_q, 8'h59)  : sec_q;
  assign min_nx  = sec_wrap  ? bcd_next(min_q, 8'h59)  : min_q;
  assign hour_nx = min_wrap  ? bcd_next(hour_q, 8'h23) : hour_q;
  assign day_nx  = hour_wrap ? day_q + DAY_W'(1)       : day_q;
  assign min_edge_o = sec_wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q  <= '0;
      min_q  <= '0;
      hour_q <= '0;
      day_q  <= '0;
    end else if (step) begin
      sec_q  <= sec_nx;
      min_q  <= min_nx;
      hour_q <= hour_nx;
      day_q  <= day_nx;
    end else begin
      if (wr_sel[0]) sec_q  <= wdata;
      if (wr_sel[1]) min_q  <= wdata;
      if (wr_sel[2]) hour_q <= wdata;
      if (wr_sel[3]) day_q[7:0] <= wdata;
      if (wr_sel[4]) day_q[DAY_W-1:8] <= wdata[HI_W-1:0];
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;
  assign day_o  = day_q;

  // R3
  sec_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && sec_q == 8'h59) |=> (sec_q == 8'h00));

  // R5
  day_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && day_q == '1 && hour_q == 8'h23 && min_q == 8'h59 && sec_q == 8'h59)
    |=> (day_q == '0));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && wr_sel == 5'b0) |=>
    ($stable(sec_q) && $stable(min_q) && $stable(hour_q) && $stable(day_q)));
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
  import tod_pkg::*;
#(
  parameter int DAY_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       wr_sel,   // 0 min, 1 hour, 2 day low, 3 day high
  input  logic [7:0]       wdata,
  input  logic             en_min,
  input  logic             en_hour,
  input  logic             en_day,
  input  logic             eval,
  input  logic [7:0]       min_nx,
  input  logic [7:0]       hour_nx,
  input  logic [DAY_W-1:0] day_nx,
  input  logic             clr,
  output logic [7:0]       amin_o,
  output logic [7:0]       ahour_o,
  output logic [DAY_W-1:0] aday_o,
  output logic             flag_o,
  output logic             hit_o
);
  localparam int HI_W = DAY_W - 8;

  logic [7:0]       amin_q, ahour_q;
  logic [DAY_W-1:0] aday_q;
  logic             flag_q, any_en, fields_ok;

  assign any_en    = en_min | en_hour | en_day;
  assign fields_ok = (!en_min  || amin_q  == min_nx) &&
                     (!en_hour || ahour_q == hour_nx) &&
                     (!en_day  || aday_q  == day_nx);
  assign hit_o     = eval && any_en && fields_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      amin_q  <= '0;
      ahour_q <= '0;
      aday_q  <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (wr_sel[0]) amin_q  <= wdata;
      if (wr_sel[1]) ahour_q <= wdata;
      if (wr_sel[2]) aday_q[7:0] <= wdata;
      if (wr_sel[3]) aday_q[DAY_W-1:8] <= wdata[HI_W-1:0];
      if (hit_o)     flag_q <= 1'b1;
      else if (clr)  flag_q <= 1'b0;
    end
  end

  assign amin_o  = amin_q;
  assign ahour_o = ahour_q;
  assign aday_o  = aday_q;
  assign flag_o  = flag_q;

  // R8
  no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_en && !flag_q) |=> !flag_q);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit_o) |=> !flag_q);

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> flag_q);
endmodule

// File: rtl/bcd_tod_calendar.sv
module bcd_tod_calendar
  import tod_pkg::*;
#(
  parameter int DAY_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq_o
);
  localparam int HI_W = DAY_W - 8;

  reg_sel_e         sel;
  logic             run_q, aien_q, men_q, hen_q, den_q;
  logic             busy, step, ctrl_wr, clr;
  logic [4:0]       time_wr;
  logic [3:0]       alarm_wr;
  logic [7:0]       sec, min, hour, sec_nx, min_nx, hour_nx, amin, ahour;
  logic [DAY_W-1:0] day, day_nx, aday;
  logic             min_edge, flag, hit;

  assign sel     = reg_sel_e'(reg_addr);
  assign busy    = tick_1hz & run_q;
  assign step    = busy;
  assign ctrl_wr = reg_wr && sel == A_CTRL;
  assign clr     = ctrl_wr && reg_wdata[C_FLAG];

  assign time_wr = {5{reg_wr && !busy}} &
                   {sel == A_DHI, sel == A_DLO, sel == A_HOUR, sel == A_MIN, sel == A_SEC};
  assign alarm_wr = {4{reg_wr}} &
                   {sel == A_ADHI, sel == A_ADLO, sel == A_AHOUR, sel == A_AMIN};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      aien_q <= 1'b0;
      men_q  <= 1'b0;
      hen_q  <= 1'b0;
      den_q  <= 1'b0;
    end else if (ctrl_wr) begin
      run_q  <= reg_wdata[C_RUN];
      aien_q <= reg_wdata[C_AIEN];
      men_q  <= reg_wdata[C_MEN];
      hen_q  <= reg_wdata[C_HEN];
      den_q  <= reg_wdata[C_DEN];
    end
  end

  tod_time_core #(.DAY_W(DAY_W)) u_time (
    .clk(clk), .rst_n(rst_n), .step(step), .wr_sel(time_wr), .wdata(reg_wdata),
    .sec_o(sec), .min_o(min), .hour_o(hour), .day_o(day),
    .sec_nx(sec_nx), .min_nx(min_nx), .hour_nx(hour_nx), .day_nx(day_nx),
    .min_edge_o(min_edge)
  );

  tod_alarm #(.DAY_W(DAY_W)) u_alarm (
    .clk(clk), .rst_n(rst_n), .wr_sel(alarm_wr), .wdata(reg_wdata),
    .en_min(men_q), .en_hour(hen_q), .en_day(den_q), .eval(min_edge),
    .min_nx(min_nx), .hour_nx(hour_nx), .day_nx(day_nx), .clr(clr),
    .amin_o(amin), .ahour_o(ahour), .aday_o(aday), .flag_o(flag), .hit_o(hit)
  );

  always_comb begin
    case (sel)
      A_CTRL:  reg_rdata = {busy, 1'b0, den_q, hen_q, men_q, flag, aien_q, run_q};
      A_SEC:   reg_rdata = sec;
      A_MIN:   reg_rdata = min;
      A_HOUR:  reg_rdata = hour;
      A_DLO:   reg_rdata = day[7:0];
      A_DHI:   reg_rdata = 8'(day[DAY_W-1:8]);
      A_AMIN:  reg_rdata = amin;
      A_AHOUR: reg_rdata = ahour;
      A_ADLO:  reg_rdata = aday[7:0];
      A_ADHI:  reg_rdata = 8'(aday[DAY_W-1:8]);
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq_o = flag & aien_q;

  // R6
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && sel == A_SEC) |=> (sec == $past(sec_nx)));

  // R10
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && aien_q && !ctrl_wr) |=> irq_o);
endmodule

// File: tb/test_bcd_tod_calendar.sv
module test_bcd_tod_calendar;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_o;

  bcd_tod_calendar i_bcd_tod_calendar (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  int rot = 0;

  // reference model: seconds of day plus a day number
  int tod_s = 0, day_n = 0;
  bit m_run = 0, m_aien = 0, m_men = 0, m_hen = 0, m_den = 0, m_flag = 0;
  int m_amin = 0, m_ahour = 0, m_aday = 0;

  function automatic int to_bcd(int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction
  function automatic int from_bcd(int b);
    return ((b >> 4) & 15) * 10 + (b & 15);
  endfunction

  function automatic int model_read(int a, bit tk);
    case (a)
      0: return ((tk && m_run) ? 128 : 0) | (m_den << 5) | (m_hen << 4) | (m_men << 3)
                | (m_flag << 2) | (m_aien << 1) | m_run;
      1: return to_bcd(tod_s % 60);
      2: return to_bcd((tod_s / 60) % 60);
      3: return to_bcd(tod_s / 3600);
      4: return day_n % 256;
      5: return day_n / 256;
      6: return m_amin;
      7: return m_ahour;
      8: return m_aday % 256;
      9: return m_aday / 256;
      default: return 0;
    endcase
  endfunction

  task automatic model_step(bit tk, bit wr, int a, int d);
    bit adv, hit;
    adv = tk && m_run;
    hit = 0;
    if (adv) begin
      tod_s = tod_s + 1;
      if (tod_s == 86400) begin
        tod_s = 0;
        day_n = (day_n + 1) % 32768;
      end
      if (tod_s % 60 == 0 && (m_men || m_hen || m_den))
        hit = (!m_men || to_bcd((tod_s / 60) % 60) == m_amin) &&
              (!m_hen || to_bcd(tod_s / 3600) == m_ahour) &&
              (!m_den || day_n == m_aday);
    end
    if (wr) begin
      case (a)
        0: begin
          m_run = d[0]; m_aien = d[1]; m_men = d[3]; m_hen = d[4]; m_den = d[5];
          if (d[2]) m_flag = 0;
        end
        1: if (!adv) tod_s = (tod_s / 60) * 60 + from_bcd(d);
        2: if (!adv) tod_s = (tod_s / 3600) * 3600 + from_bcd(d) * 60 + tod_s % 60;
        3: if (!adv) tod_s = from_bcd(d) * 3600 + tod_s % 3600;
        4: if (!adv) day_n = (day_n / 256) * 256 + d;
        5: if (!adv) day_n = (day_n % 256) + (d % 128) * 256;
        6: m_amin = d;
        7: m_ahour = d;
        8: m_aday = (m_aday / 256) * 256 + d;
        9: m_aday = (m_aday % 256) + (d % 128) * 256;
        default: ;
      endcase
    end
    if (hit) m_flag = 1;
  endtask

  task automatic cyc(bit tk, bit wr, int a, int d);
    int exp_rd;
    bit exp_irq;
    @(negedge clk);
    tick_1hz = tk; reg_wr = wr; reg_addr = 4'(a); reg_wdata = 8'(d);
    #1;
    exp_rd  = model_read(a, tk);
    exp_irq = m_flag && m_aien;
    n_cmp++;
    if (int'(reg_rdata) != exp_rd) begin
      n_bad++;
      $display("FAIL %s addr=%0h rdata got %02h expected %02h", cur_req, a, reg_rdata, exp_rd);
    end
    n_cmp++;
    if (irq_o != exp_irq) begin
      n_bad++;
      $display("FAIL %s irq_o got %0b expected %0b", cur_req, irq_o, exp_irq);
    end
    @(posedge clk);
    model_step(tk, wr, a, d);
  endtask

  task automatic idle(bit tk);
    cyc(tk, 0, rot, 0);
    rot = (rot + 1) % 12;
  endtask

  task automatic set_time(int h, int m, int s);
    cyc(0, 1, 3, h);
    cyc(0, 1, 2, m);
    cyc(0, 1, 1, s);
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired (all requirements)");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1";
    for (int i = 0; i < 12; i++) cyc(0, 0, i, 0);

    cur_req = "R2";
    cyc(0, 1, 6, 8'h47); cyc(0, 1, 7, 8'h13);
    cyc(0, 1, 8, 8'hAB); cyc(0, 1, 9, 8'hFF);
    cyc(0, 1, 4, 8'h34); cyc(0, 1, 5, 8'h92);
    for (int i = 0; i < 12; i++) cyc(0, 0, i, 0);

    cur_req = "R3";
    set_time(8'h09, 8'h59, 8'h58);
    cyc(0, 1, 0, 8'h01);
    for (int i = 0; i < 3; i++) idle(1);
    for (int i = 1; i < 6; i++) cyc(0, 0, i, 0);

    cur_req = "R5";
    cyc(0, 1, 4, 8'hFF); cyc(0, 1, 5, 8'h7F);
    set_time(8'h23, 8'h59, 8'h58);
    for (int i = 0; i < 3; i++) idle(1);
    for (int i = 1; i < 6; i++) cyc(0, 0, i, 0);

    cur_req = "R4";
    cyc(0, 1, 0, 8'h00);
    for (int i = 0; i < 6; i++) cyc(1, 0, 1 + i % 5, 0);
    cyc(0, 1, 0, 8'h01);
    idle(1);

    cur_req = "R6";
    cyc(1, 0, 0, 0);
    cyc(1, 1, 1, 8'h30);
    cyc(1, 1, 3, 8'h05);
    cyc(0, 0, 1, 0);
    cyc(1, 1, 6, 8'h05);
    cyc(1, 1, 0, 8'h01);
    cyc(0, 0, 6, 0);

    cur_req = "R7";
    cyc(0, 1, 7, 8'h10);
    cyc(0, 1, 8, 8'h00); cyc(0, 1, 9, 8'h00);
    set_time(8'h10, 8'h04, 8'h58);
    cyc(0, 1, 0, 8'h0B);
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);

    cur_req = "R10";
    cyc(0, 0, 0, 0);
    cyc(0, 1, 0, 8'h09);
    cyc(0, 1, 0, 8'h0B);

    cur_req = "R9";
    cyc(0, 1, 0, 8'h0B);
    cyc(0, 0, 0, 0);
    cyc(0, 1, 0, 8'h4F);
    cyc(0, 0, 0, 0);

    cur_req = "R8";
    cyc(0, 1, 0, 8'h03);
    set_time(8'h10, 8'h04, 8'h59);
    cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0);

    cur_req = "R7";
    cyc(0, 1, 8, 8'h01);
    cyc(0, 1, 0, 8'h3B);
    set_time(8'h10, 8'h04, 8'h59);
    cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0);
    cyc(0, 1, 8, 8'h00);
    set_time(8'h10, 8'h04, 8'h59);
    cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0);

    cur_req = "R9";
    set_time(8'h10, 8'h04, 8'h59);
    cyc(1, 1, 0, 8'h3F);
    cyc(0, 0, 0, 0);
    cyc(0, 1, 0, 8'h3F);
    cyc(0, 0, 0, 0);

    cur_req = "R3";
    cyc(0, 1, 0, 8'h0B);
    set_time(8'h10, 8'h03, 8'h40);
    for (int i = 0; i < 200; i++) idle((i % 3) != 2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule